// File: doc/BRIEF.md
# Two-Slot Elastic Channel Buffer

This block takes the place of a plain pipeline register on a latency-insensitive channel. Both sides of the block use the same three-wire handshake: a data word, a valid wire that the sender drives forward, and a stop wire that the receiver drives backward. A word moves across a channel edge only when valid is high and stop is low (a transfer). Valid low is a bubble, whatever stop is doing. Valid high with stop high is a retry, and during a retry the sender keeps both the word and valid steady.

Storage has two slots, and each slot is a half-stage with its own load enable. The main slot drives the downstream channel. The skid slot catches a word that arrives while the main slot is stalled. The stop wire sent upstream comes straight from a register and depends only on how full the buffer is. No combinational path runs from the downstream stop to the upstream side. A slot's data register loads only in a cycle where it captures a word. Words leave in the order they arrived, and none is dropped or repeated.

Top module: `elastic_buf`

## Requirements
- R1: During reset (`rst_n` low at a clock edge) both slots are emptied, so after that edge `dn_valid` is 0 and `up_stop` is 0.
- R2: `dn_valid` is high exactly when at least one accepted word is held inside the block. A word offered with `up_valid` low is never stored.
- R3: The words on the downstream channel are exactly the accepted upstream words, in the same order, with none lost and none duplicated, under any stop pattern.
- R4: After a downstream retry cycle (`dn_valid`=1, `dn_stop`=1), in the next cycle `dn_valid` is still 1 and `dn_data` is unchanged.
- R5: `up_stop` is a register output. It is 1 exactly when both slots hold words.
- R6: When `up_valid` is held high and `dn_stop` is held low, one word passes per cycle with no bubbles after the first.
- R7: A word accepted at a clock edge while the block is empty shows up on `dn_data` with `dn_valid`=1 right after that same edge.
- R8: With `dn_stop` held high from the empty state, the block accepts exactly two words and then holds `up_stop` high.
- R9: When no word is captured, the data registers do not load. While the block is empty, changes on `up_data` with `up_valid` low leave `dn_data` at the last word delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| up_valid | input | 1 | Upstream sender offers a word |
| up_data | input | DATA_W | Upstream word |
| up_stop | output | 1 | Backpressure to the upstream sender (registered) |
| dn_valid | output | 1 | A word is offered downstream |
| dn_data | output | DATA_W | Downstream word |
| dn_stop | input | 1 | Backpressure from the downstream receiver |

## Verification
The assertions check the local rules on every cycle: the reset state, the downstream retry hold, `up_stop` matching the skid-slot occupancy, the skid slot holding a word only behind an occupied main slot, and no slot being loaded over a word that is not leaving. Ordering, the absence of loss or duplication, the two-word capacity, the full-rate streaming and the hold of `dn_data` while empty are end-to-end properties of the token stream. Only the bench's scoreboard, running directed and random valid/stop patterns, can show those.

// File: rtl/elastic_buf_pkg.sv
// Package for the elastic buffer: shared types.
// Assumes nothing beyond IEEE 1800-2017.
package elastic_buf_pkg;
    // Selects where the main slot takes its next word from
    typedef enum logic {
        SRC_UPSTREAM = 1'b0,
        SRC_SKID     = 1'b1
    } main_src_e;
endpackage

// File: rtl/eb_slot.sv
// One half-stage: a valid flag and a data register that loads only on capture.
// Assumes: the controller never asserts ld_en and clr_en with conflicting intent;
// load takes priority, so a slot can be refilled in the cycle it is vacated.
module eb_slot #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic              clr_en,
    input  logic [DATA_W-1:0] din,
    output logic              vld,
    output logic [DATA_W-1:0] dout
);
    // Occupancy flag: set on capture, cleared when the word leaves
    always_ff @(posedge clk) begin
        if (!rst_n)      vld <= 1'b0;
        else if (ld_en)  vld <= 1'b1;
        else if (clr_en) vld <= 1'b0;
    end

    // Data register: clocked only when a word is captured
    always_ff @(posedge clk) begin
        if (ld_en) dout <= din;
    end

    // A held word may be overwritten only in the cycle it leaves (R3)
    assert_no_clobber_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && vld) |-> clr_en);
endmodule

// File: rtl/eb_ctrl.sv
// Control for the two half-stages. It decides captures and releases and
// produces the registered upstream stop.
// Assumes: the upstream sender holds its word during a retry.
module eb_ctrl
    import elastic_buf_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      up_valid,
    input  logic      dn_stop,
    input  logic      main_v,
    input  logic      skid_v,
    output logic      main_ld,
    output logic      main_clr,
    output main_src_e main_src,
    output logic      skid_ld,
    output logic      skid_clr,
    output logic      up_stop
);
    logic stop_q;
    logic accept;
    logic main_free;
    logic stop_nxt;

    // Handshake decode and slot enables
    always_comb begin
        accept    = up_valid && !stop_q;
        main_free = !main_v || !dn_stop;
        main_clr  = main_v && !dn_stop;
        main_ld   = main_free && (skid_v || accept);
        main_src  = skid_v ? SRC_SKID : SRC_UPSTREAM;
        skid_ld   = !main_free && accept;
        skid_clr  = main_free && skid_v;
        stop_nxt  = (skid_v && !skid_clr) || skid_ld;
    end

    // Upstream stop register: high while the skid slot will be occupied
    always_ff @(posedge clk) begin
        if (!rst_n) stop_q <= 1'b0;
        else        stop_q <= stop_nxt;
    end

    assign up_stop = stop_q;

    // Stop is raised only while both slots hold words (R5)
    assert_stop_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        up_stop |-> (main_v && skid_v));
    // Stop register follows skid occupancy (R5)
    assert_stop_tracks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        up_stop == skid_v);
    // Skid never holds a word ahead of an empty main slot (R3)
    assert_skid_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        skid_v |-> main_v);
endmodule

// File: rtl/elastic_buf.sv
// Two-slot elastic buffer on a valid/stop channel. The main slot feeds the
// downstream side and the skid slot absorbs one word during a stall.
// Assumes: synchronous active-low reset; the senders obey the retry rule.
module elastic_buf
    import elastic_buf_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_valid,
    input  logic [DATA_W-1:0] up_data,
    output logic              up_stop,
    output logic              dn_valid,
    output logic [DATA_W-1:0] dn_data,
    input  logic              dn_stop
);
    logic              main_ld, main_clr, skid_ld, skid_clr;
    logic              main_v, skid_v;
    main_src_e         main_src;
    logic [DATA_W-1:0] skid_q;
    logic [DATA_W-1:0] main_d;

    eb_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_valid (up_valid),
        .dn_stop  (dn_stop),
        .main_v   (main_v),
        .skid_v   (skid_v),
        .main_ld  (main_ld),
        .main_clr (main_clr),
        .main_src (main_src),
        .skid_ld  (skid_ld),
        .skid_clr (skid_clr),
        .up_stop  (up_stop)
    );

    // Main-slot input: the skid word has priority so that order is kept
    always_comb begin
        main_d = (main_src == SRC_SKID) ? skid_q : up_data;
    end

    eb_slot #(.DATA_W(DATA_W)) u_skid (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_en  (skid_ld),
        .clr_en (skid_clr),
        .din    (up_data),
        .vld    (skid_v),
        .dout   (skid_q)
    );

    eb_slot #(.DATA_W(DATA_W)) u_main (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_en  (main_ld),
        .clr_en (main_clr),
        .din    (main_d),
        .vld    (main_v),
        .dout   (dn_data)
    );

    assign dn_valid = main_v;

    // Reset empties the buffer (R1)
    assert_reset_empty_R1: assert property (@(posedge clk)
        !rst_n |=> (!dn_valid && !up_stop));
    // Downstream retry holds the word (R4)
    assert_retry_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && dn_stop) |=> (dn_valid && $stable(dn_data)));
endmodule

// File: tb/tb_elastic_buf.sv
module tb_elastic_buf;
    localparam int W = 16;
    localparam int MAX_CYC = 200000;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         up_valid;
    logic [W-1:0] up_data;
    logic         up_stop;
    logic         dn_valid;
    logic [W-1:0] dn_data;
    logic         dn_stop;

    int tests = 0;
    int fails = 0;
    logic [W-1:0] sb[$];
    logic         prev_retry = 1'b0;
    logic [W-1:0] prev_word  = '0;
    int up_xfers = 0;
    int dn_xfers = 0;

    elastic_buf #(.DATA_W(W)) dut (.*);

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One cycle: drive inputs after the falling edge, then check and score
    // the transfers that the next rising edge will perform
    task automatic step(input logic v, input logic [W-1:0] d, input logic s);
        @(negedge clk);
        up_valid = v; up_data = d; dn_stop = s;
        #1;
        check(up_stop == (sb.size() == 2), "R5", up_stop, sb.size() == 2);
        check(dn_valid == (sb.size() != 0), "R2", dn_valid, sb.size() != 0);
        if (prev_retry) begin
            check(dn_valid && dn_data == prev_word, "R4", dn_data, prev_word);
        end
        if (dn_valid && !dn_stop) begin
            if (sb.size() == 0) check(1'b0, "R3", dn_data, 0);
            else check(dn_data == sb.pop_front(), "R3", dn_data, 0);
            dn_xfers++;
        end
        if (up_valid && !up_stop) begin
            sb.push_back(up_data);
            up_xfers++;
        end
        prev_retry = dn_valid && dn_stop;
        prev_word  = dn_data;
    endtask

    initial begin
        #(MAX_CYC * 4);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", MAX_CYC, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [W-1:0] hold_d;
        logic         hold_v;
        logic [W-1:0] last;
        int n;
        rst_n = 1'b0; up_valid = 1'b0; up_data = '0; dn_stop = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!dn_valid && !up_stop, "R1", {dn_valid, up_stop}, 0);
        rst_n = 1'b1;

        // R7: single word through an empty buffer
        step(1'b1, 16'hA5A5, 1'b0);
        step(1'b0, 16'h0000, 1'b0);
        check(dn_valid && dn_data == 16'hA5A5, "R7", dn_data, 16'hA5A5);
        step(1'b0, 16'h0000, 1'b0);

        // R8: downstream stopped, fill to capacity; data held during retry
        n = up_xfers;
        for (int i = 0; i < 6; i++) step(1'b1, W'(16'h0100 + (up_xfers - n)), 1'b1);
        check(up_xfers - n == 2, "R8", up_xfers - n, 2);
        check(up_stop == 1'b1, "R8", up_stop, 1);

        // Drain, then R9: idle inputs with garbage data leave dn_data unchanged
        for (int i = 0; i < 4; i++) step(1'b0, 16'hDEAD, 1'b0);
        last = 16'h0101;
        for (int i = 0; i < 4; i++) step(1'b0, W'($urandom), i[0]);
        check(!dn_valid && dn_data == last, "R9", dn_data, last);

        // R6: streaming at full rate
        step(1'b1, 16'h2000, 1'b0);
        n = dn_xfers;
        for (int i = 1; i < 20; i++) step(1'b1, W'(16'h2000 + i), 1'b0);
        check(dn_xfers - n == 19, "R6", dn_xfers - n, 19);
        for (int i = 0; i < 3; i++) step(1'b0, 16'h0, 1'b0);

        // Random valid/stop patterns against the scoreboard (R3)
        void'($urandom(32'd1234));
        hold_v = 1'b0; hold_d = '0;
        for (int i = 0; i < 4000; i++) begin
            if (!(hold_v && up_stop)) begin
                hold_v = ($urandom % 3) != 0;
                hold_d = W'($urandom);
            end
            step(hold_v, hold_d, ($urandom % 4) == 0 || (i % 97) < 6);
        end
        for (int i = 0; i < 6; i++) step(1'b0, 16'h0, 1'b0);
        check(sb.size() == 0, "R3", sb.size(), 0);
        check(up_xfers == dn_xfers, "R3", dn_xfers, up_xfers);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule